// File: doc/BRIEF.md
# Battery Mode and Fault Supervisor

This block is the digital control core of a battery charge and discharge manager. A host sends it a command byte over a serial shift port. The byte selects one of four operating modes: shutdown, idle, discharge or charge. From that mode the block drives enable lines for the analog power domain, the fuel gauge, the charge loop and the discharge driver. The analog regulation, PWM, ADC and temperature sensing sit outside the block. They appear here only as enables and as flag inputs.

The block watches seven battery and fault flags. Each flag passes through a two-flop synchroniser. Charge and discharge each have their own set of flags that can block them, and each ignores one cell-voltage flag. When a blocking flag is seen in an active mode, the block sets a sticky fail-safe state that holds both power paths off. Only a complete command byte that carries the clear request releases it.

The mode bits take effect as soon as the third bit of the byte has arrived, before the byte is complete. This gives the charge loop time to settle before a measurement is taken. During the same transfer the block shifts out an 8-bit status byte: the seven synchronised flags and the fail-safe bit.

Top module: `batt_supervisor`

## Requirements
- R1: After reset, and whenever the shutdown bit (first bit sent, byte bit 7) is 1, the block is in shutdown: `ana_pwr_en`, `gauge_en`, `chg_en` and `dis_en` are all 0, whatever the two mode bits are. The fail-safe bit is clear after reset.
- R2: When the shutdown bit is 0, the mode bits (byte bits 6:5) select the mode: 00 is idle, 01 is discharge, 10 is charge and 11 is idle. `ana_pwr_en` is 1 in every mode except shutdown.
- R3: In idle, `chg_en`, `dis_en` and `gauge_en` are 0. `gauge_en` is 1 in charge and in discharge.
- R4: In charge, `chg_en` is 1 only while present=1, removed=0, and over-voltage, hot, cold and timeout are all 0, with fail-safe clear. The under-voltage flag has no effect in charge.
- R5: In discharge, `dis_en` is 1 only while present=1, removed=0, and under-voltage, hot, cold and timeout are all 0, with fail-safe clear. The over-voltage flag has no effect in discharge.
- R6: A blocking flag in charge or discharge sets the fail-safe bit. While fail-safe is set, `chg_en` and `dis_en` are both 0.
- R7: Fail-safe stays set after the fault goes away. It clears only at the end of a complete 8-bit transfer whose clear bit (fourth bit sent, byte bit 4) is 1.
- R8: The mode is applied on the third rising SCLK edge of a transfer, before the remaining bits arrive. It then persists until another transfer changes it.
- R9: The status byte is captured when chip select falls and is shifted out MSB first. Data changes on falling SCLK edges. The layout is bit7 present, bit6 removed, bit5 over-voltage, bit4 under-voltage, bit3 hot, bit2 cold, bit1 timeout, bit0 fail-safe.
- R10: If chip select rises before the eighth bit, the clear request is discarded. A mode whose three bits had already arrived stays applied.
- R11: A flag change is synchronised by two flops. The enables react on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock (SPI mode 0) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Command data in, MSB first |
| spi_miso | output | 1 | Status data out, MSB first |
| bat_present | input | 1 | Battery detected |
| bat_removed | input | 1 | Battery removal event |
| cell_over_v | input | 1 | Cell voltage above maximum |
| cell_under_v | input | 1 | Cell voltage below minimum |
| temp_hot | input | 1 | High temperature limit exceeded |
| temp_cold | input | 1 | Low temperature limit exceeded |
| timer_expired | input | 1 | Time limit exceeded |
| ana_pwr_en | output | 1 | Analog power domain enable |
| gauge_en | output | 1 | Fuel gauge enable |
| chg_en | output | 1 | Charge loop enable |
| dis_en | output | 1 | Discharge driver enable |

## Verification
A flag change reaches the enables on the third rising clock edge. The bench changes flags on a falling clock edge and checks the enables after exactly two rising edges and again after three. The serial lines are synchronised inside the block, so a new mode shows at the enables on the fifth clock edge after its SCLK rise, and MISO moves on the third edge after an SCLK fall. The bench holds each SCLK phase for eight or more clocks and samples outputs only after a whole phase, so every result has settled. It checks the mid-transfer mode change after bit three, before the byte ends.

// File: rtl/batt_sup_pkg.sv
package batt_sup_pkg;
  typedef enum logic [1:0] {
    MODE_SHDN  = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_DISCH = 2'd2,
    MODE_CHG   = 2'd3
  } batt_mode_t;

  localparam int NUM_FLAGS = 7;
  // flag vector positions (MSB first in the status byte)
  localparam int F_PRESENT = 6;
  localparam int F_REMOVED = 5;
  localparam int F_OVER    = 4;
  localparam int F_UNDER   = 3;
  localparam int F_HOT     = 2;
  localparam int F_COLD    = 1;
  localparam int F_TIMEOUT = 0;

  // {shutdown, mode1, mode0} -> operating mode
  function automatic batt_mode_t decode_mode(input logic [2:0] bits);
    if (bits[2])            return MODE_SHDN;
    else if (bits[1:0] == 2'b01) return MODE_DISCH;
    else if (bits[1:0] == 2'b10) return MODE_CHG;
    else                    return MODE_IDLE;
  endfunction
endpackage

// File: rtl/bsup_sync.sv
module bsup_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= RST_VAL;
      else     stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/bsup_spi.sv
module bsup_spi #(
  parameter int CMD_W  = 8,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [STAT_W-1:0] status,
  output logic              mode_load,
  output logic [2:0]        mode_bits,
  output logic              fs_clear,
  output logic              miso
);
  localparam int CNT_W   = $clog2(CMD_W + 1);
  localparam int IDX_PS  = 0;
  localparam int IDX_M1  = 1;
  localparam int IDX_M0  = 2;
  localparam int IDX_CLR = 3;

  logic              sclk_d, cs_d;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        hdr;
  logic              clr_bit;
  logic [STAT_W-1:0] tx_sh;
  logic              rise, fall, cs_start;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign cs_start = ~cs_n_s & cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
      cnt       <= '0;
      hdr       <= '0;
      clr_bit   <= 1'b0;
      tx_sh     <= '0;
      miso      <= 1'b0;
      mode_load <= 1'b0;
      mode_bits <= 3'b100;
      fs_clear  <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      cs_d      <= cs_n_s;
      mode_load <= 1'b0;
      fs_clear  <= 1'b0;
      if (cs_start) begin
        cnt     <= '0;
        clr_bit <= 1'b0;
        tx_sh   <= status;
        miso    <= status[STAT_W-1];
      end else if (!cs_n_s) begin
        if (rise && cnt != CNT_W'(CMD_W)) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(IDX_PS))  hdr[1]  <= mosi_s;
          if (cnt == CNT_W'(IDX_M1))  hdr[0]  <= mosi_s;
          if (cnt == CNT_W'(IDX_M0)) begin
            mode_load <= 1'b1;
            mode_bits <= {hdr, mosi_s};
          end
          if (cnt == CNT_W'(IDX_CLR)) clr_bit <= mosi_s;
          if (cnt == CNT_W'(CMD_W - 1)) fs_clear <= clr_bit;
        end
        if (fall) begin
          tx_sh <= tx_sh << 1;
          miso  <= tx_sh[STAT_W-2];
        end
      end
    end
  end
endmodule

// File: rtl/bsup_ctrl.sv
module bsup_ctrl
  import batt_sup_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_load,
  input  logic [2:0]           mode_bits,
  input  logic                 fs_clear,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 chg_en,
  output logic                 dis_en,
  output logic                 gauge_en,
  output logic                 ana_en,
  output logic                 failsafe
);
  batt_mode_t mode_q;
  logic common_ok, chg_ok, dis_ok, fault_now;

  assign common_ok = flags[F_PRESENT] & ~flags[F_REMOVED] & ~flags[F_HOT]
                   & ~flags[F_COLD] & ~flags[F_TIMEOUT];
  assign chg_ok    = common_ok & ~flags[F_OVER];
  assign dis_ok    = common_ok & ~flags[F_UNDER];
  assign fault_now = ((mode_q == MODE_CHG) & ~chg_ok)
                   | ((mode_q == MODE_DISCH) & ~dis_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_SHDN;
      failsafe <= 1'b0;
      chg_en   <= 1'b0;
      dis_en   <= 1'b0;
      gauge_en <= 1'b0;
      ana_en   <= 1'b0;
    end else begin
      if (mode_load) mode_q <= decode_mode(mode_bits);
      if (fs_clear)       failsafe <= 1'b0;
      else if (fault_now) failsafe <= 1'b1;
      chg_en   <= (mode_q == MODE_CHG) & chg_ok & ~failsafe;
      dis_en   <= (mode_q == MODE_DISCH) & dis_ok & ~failsafe;
      gauge_en <= (mode_q == MODE_CHG) | (mode_q == MODE_DISCH);
      ana_en   <= (mode_q != MODE_SHDN);
    end
  end
endmodule

// File: rtl/batt_supervisor.sv
module batt_supervisor
  import batt_sup_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic bat_present,
  input  logic bat_removed,
  input  logic cell_over_v,
  input  logic cell_under_v,
  input  logic temp_hot,
  input  logic temp_cold,
  input  logic timer_expired,
  output logic ana_pwr_en,
  output logic gauge_en,
  output logic chg_en,
  output logic dis_en
);
  localparam int STAT_W = NUM_FLAGS + 1;

  logic [NUM_FLAGS-1:0] flags_raw, flags_s;
  logic [2:0]           spi_raw, spi_s;
  logic                 mode_load, fs_clear, failsafe;
  logic [2:0]           mode_bits;

  assign flags_raw = {bat_present, bat_removed, cell_over_v, cell_under_v,
                      temp_hot, temp_cold, timer_expired};
  assign spi_raw   = {spi_sclk, spi_cs_n, spi_mosi};

  bsup_sync #(.W(NUM_FLAGS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_flag_sync (
    .clk(clk), .rst(rst), .din(flags_raw), .dout(flags_s)
  );

  bsup_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_spi_sync (
    .clk(clk), .rst(rst), .din(spi_raw), .dout(spi_s)
  );

  bsup_spi #(.CMD_W(CMD_W), .STAT_W(STAT_W)) u_spi (
    .clk(clk), .rst(rst),
    .sclk_s(spi_s[2]), .cs_n_s(spi_s[1]), .mosi_s(spi_s[0]),
    .status({flags_s, failsafe}),
    .mode_load(mode_load), .mode_bits(mode_bits),
    .fs_clear(fs_clear), .miso(spi_miso)
  );

  bsup_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .mode_load(mode_load), .mode_bits(mode_bits), .fs_clear(fs_clear),
    .flags(flags_s),
    .chg_en(chg_en), .dis_en(dis_en), .gauge_en(gauge_en),
    .ana_en(ana_pwr_en), .failsafe(failsafe)
  );
endmodule

// File: rtl/batt_supervisor_chk.sv
module batt_supervisor_chk
  import batt_sup_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 ana_pwr_en,
  input logic                 gauge_en,
  input logic                 chg_en,
  input logic                 dis_en,
  input logic                 failsafe,
  input logic                 fs_clear,
  input logic [NUM_FLAGS-1:0] flags_s
);
  // R1: no power path or gauge without the analog domain
  a_r1_shdn_all_off: assert property (@(posedge clk) disable iff (rst)
    !ana_pwr_en |-> (!chg_en && !dis_en && !gauge_en));

  // R4: charge enable implies the charge-blocking flags were clear
  a_r4_chg_needs_ok: assert property (@(posedge clk) disable iff (rst)
    chg_en |-> $past(flags_s[F_PRESENT] && !flags_s[F_REMOVED] && !flags_s[F_OVER]
                     && !flags_s[F_HOT] && !flags_s[F_COLD] && !flags_s[F_TIMEOUT]));

  // R5: discharge enable implies the discharge-blocking flags were clear
  a_r5_dis_needs_ok: assert property (@(posedge clk) disable iff (rst)
    dis_en |-> $past(flags_s[F_PRESENT] && !flags_s[F_REMOVED] && !flags_s[F_UNDER]
                     && !flags_s[F_HOT] && !flags_s[F_COLD] && !flags_s[F_TIMEOUT]));

  // R6: fail-safe holds both power paths off
  a_r6_fs_blocks: assert property (@(posedge clk) disable iff (rst)
    failsafe |-> (!chg_en && !dis_en));

  // R7: fail-safe only falls after a completed clear request
  a_r7_fs_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(failsafe) |-> $past(fs_clear));

  // R2: modes are mutually exclusive
  a_r2_one_path: assert property (@(posedge clk) disable iff (rst)
    !(chg_en && dis_en));
endmodule

bind batt_supervisor batt_supervisor_chk u_chk (
  .clk(clk), .rst(rst), .ana_pwr_en(ana_pwr_en), .gauge_en(gauge_en),
  .chg_en(chg_en), .dis_en(dis_en), .failsafe(failsafe),
  .fs_clear(fs_clear), .flags_s(flags_s)
);

// File: tb/tb_batt_supervisor.sv
`timescale 1ns/1ps
module tb_batt_supervisor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic present = 1'b1, removed = 1'b0, over_v = 1'b0, under_v = 1'b0;
  logic hot = 1'b0, cold = 1'b0, tout = 1'b0;
  logic ana, gauge, chg, dis;
  int   n_chk = 0, n_bad = 0;
  logic [7:0] st;

  // command bytes: bit7 shutdown, bits6:5 mode, bit4 clear request
  localparam logic [7:0] C_SHDN  = 8'h80;
  localparam logic [7:0] C_SHDN3 = 8'hE0;
  localparam logic [7:0] C_IDLE  = 8'h00;
  localparam logic [7:0] C_IDLE3 = 8'h60;
  localparam logic [7:0] C_DIS   = 8'h20;
  localparam logic [7:0] C_CHG   = 8'h40;
  localparam logic [7:0] C_CLR   = 8'h10;

  always #5 clk = ~clk;

  batt_supervisor dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .bat_present(present), .bat_removed(removed),
    .cell_over_v(over_v), .cell_under_v(under_v), .temp_hot(hot),
    .temp_cold(cold), .timer_expired(tout), .ana_pwr_en(ana),
    .gauge_en(gauge), .chg_en(chg), .dis_en(dis)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // enables packed as {ana, gauge, chg, dis}
  function automatic logic [7:0] en();
    return {4'b0, ana, gauge, chg, dis};
  endfunction

  task automatic spi_begin();
    clks(1); cs_n = 1'b0; clks(8);
  endtask

  task automatic spi_bit(input logic b, output logic o);
    mosi = b; clks(4); o = miso;
    sclk = 1'b1; clks(8);
    sclk = 1'b0; clks(4);
  endtask

  task automatic spi_end();
    clks(4); cs_n = 1'b1; clks(10);
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nbits, output logic [7:0] s);
    logic o;
    s = '0;
    spi_begin();
    for (int i = 0; i < nbits; i++) begin
      spi_bit(cmd[7-i], o);
      s[7-i] = o;
    end
    spi_end();
  endtask

  task automatic t_reset();
    check("R1 reset enables", en(), 8'h00);
    xfer(C_SHDN, 8, st);
    check("R9 status after reset", st, 8'b1000_0000);
    check("R1 shutdown enables", en(), 8'h00);
  endtask

  task automatic t_decode();
    xfer(C_SHDN3, 8, st);
    check("R1 shutdown ignores mode bits", en(), 8'h00);
    xfer(C_IDLE, 8, st);
    check("R3 idle enables", en(), 8'b1000);
    xfer(C_IDLE3, 8, st);
    check("R2 mode 11 is idle", en(), 8'b1000);
  endtask

  task automatic t_charge();
    xfer(C_CHG, 8, st);
    check("R4 charge enables", en(), 8'b1110);
    under_v = 1'b1; clks(6);
    check("R4 under-voltage ignored in charge", en(), 8'b1110);
    xfer(C_CHG, 8, st);
    check("R9 status with under-voltage", st, 8'b1001_0000);
    check("R4 still charging", en(), 8'b1110);
    under_v = 1'b0; clks(6);
    xfer(C_IDLE, 8, st);
    check("R8 idle stops charging", en(), 8'b1000);
  endtask

  task automatic t_discharge();
    xfer(C_DIS, 8, st);
    check("R5 discharge enables", en(), 8'b1101);
    over_v = 1'b1; clks(6);
    check("R5 over-voltage ignored in discharge", en(), 8'b1101);
    over_v = 1'b0; clks(6);
  endtask

  task automatic t_fault_charge();
    xfer(C_CHG, 8, st);
    check("R4 charge before fault", en(), 8'b1110);
    hot = 1'b1;                 // driven at a falling edge
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11 still on after two edges", {7'b0, chg}, 8'd1);
    @(posedge clk); @(negedge clk);
    check("R11 off on third edge", {7'b0, chg}, 8'd0);
    clks(4);
    check("R6 charge forced off", en(), 8'b1100);
    xfer(C_CHG, 8, st);
    check("R9 status hot and fail-safe", st, 8'b1000_1001);
    hot = 1'b0; clks(8);
    check("R7 fail-safe holds after fault clears", en(), 8'b1100);
    xfer(C_CHG | C_CLR, 8, st);
    check("R9 status captured before clear", st, 8'b1000_0001);
    check("R7 clear request restores charge", en(), 8'b1110);
  endtask

  task automatic t_fault_discharge_abort();
    xfer(C_DIS, 8, st);
    under_v = 1'b1; clks(8);
    check("R6 under-voltage blocks discharge", en(), 8'b1100);
    under_v = 1'b0; clks(8);
    xfer(C_DIS | C_CLR, 4, st);
    check("R10 aborted clear discarded", en(), 8'b1100);
    xfer(C_DIS, 8, st);
    check("R10 fail-safe still set", st[0 +: 1], 1'b1);
    xfer(C_IDLE | C_CLR, 8, st);
    check("R7 cleared into idle", en(), 8'b1000);
    xfer(C_CHG, 3, st);
    check("R10 mode kept after abort at bit 3", en(), 8'b1110);
    xfer(C_SHDN, 8, st);
    check("R9 status fail-safe clear", st, 8'b1000_0000);
    removed = 1'b1;
    xfer(C_DIS, 8, st);
    clks(6);
    check("R5 removed blocks discharge", en(), 8'b1100);
    removed = 1'b0;
    xfer(C_IDLE | C_CLR, 8, st);
    check("R7 clear after removal", en(), 8'b1000);
  endtask

  task automatic t_midword();
    logic o;
    spi_begin();
    spi_bit(1'b0, o); spi_bit(1'b0, o); spi_bit(1'b1, o);  // discharge
    check("R8 mode applied after third bit", en(), 8'b1101);
    for (int i = 0; i < 5; i++) spi_bit(1'b0, o);
    spi_end();
    check("R8 mode persists after word", en(), 8'b1101);
  endtask

  initial begin
    clks(4); rst = 1'b0; clks(4);
    t_reset();
    t_decode();
    t_charge();
    t_discharge();
    t_fault_charge();
    t_fault_discharge_abort();
    t_midword();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule